// File: doc/BRIEF.md
# Single-Digit Decimal/Binary Multiplier

This block multiplies two 4-bit digit operands in a single combinational step. When the mode select chooses decimal, each operand is taken as one BCD digit. The output byte then holds the product as two BCD digits: tens in the upper nibble and units in the lower nibble, covering 0 to 81. When the mode select chooses binary, any operand value from 0 to 15 is accepted and the output byte is their plain unsigned product.

Both modes use one datapath. Each operand is split into its top bit and a 3-bit remainder, so the product becomes the sum of a small 3x3 core product, two cross terms shifted by three, and a constant 64 when both top bits are set. For a valid BCD digit with the top bit set, the remainder can only be 0 or 1. Because of this, only the four pairs drawn from {8, 9} x {8, 9} use every term. All other valid pairs are formed from the 3x3 core plus at most one shifted cross term. In decimal mode the binary sum is split into tens and units by a reciprocal-scaling step. If either digit is above 9 in decimal mode, a flag is raised and the output byte is forced to zero.

Top module: `digit_mul`

## Requirements
- R1: With `hex_sel` = 1, `prod` equals the unsigned product of `op_a` and `op_b` for every pair of values 0 to 15.
- R2: With `hex_sel` = 1, `bad_digit` is 0 whatever the operands.
- R3: With `hex_sel` = 0 and both operands at most 9, `prod[7:4]` × 10 + `prod[3:0]` equals `op_a` × `op_b`.
- R4: With `hex_sel` = 0 and both operands at most 9, each nibble of `prod` is at most 9.
- R5: With `hex_sel` = 0 and either operand above 9, `bad_digit` is 1 and `prod` is 8'h00. With `hex_sel` = 0 and both operands at most 9, `bad_digit` is 0.
- R6: In decimal mode the four pairs with both digits in {8, 9} give 8'h64, 8'h72, 8'h72 and 8'h81. The largest result, 9 × 9, gives 8'h81.
- R7: Any operand equal to 0 gives `prod` = 8'h00 in both modes.
- R8: The block holds no state. Its outputs follow its inputs within the same cycle, and they depend only on the present input values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 4 | First digit operand |
| op_b | input | 4 | Second digit operand |
| hex_sel | input | 1 | 1 = binary product, 0 = two-digit BCD product |
| prod | output | 8 | Product: binary, or {tens, units} in BCD |
| bad_digit | output | 1 | Decimal mode with an operand above 9 |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between inputs and outputs. The bench changes the operands and the mode on a falling clock edge and samples the outputs two nanoseconds later, well before the next rising edge. A result therefore never overlaps the next stimulus. To show that no earlier input is remembered (R8), each operand pair is applied in both modes in turn, and it is also revisited after unrelated pairs.

// File: rtl/digit_mul.sv
module digit_mul #(
  parameter int DW = 4
) (
  input  logic [DW-1:0]   op_a,
  input  logic [DW-1:0]   op_b,
  input  logic            hex_sel,
  output logic [2*DW-1:0] prod,
  output logic            bad_digit
);
  localparam int PW = 2 * DW;
  localparam int LW = DW - 1;

  logic          a_top, b_top;
  logic [LW-1:0] a_low, b_low;
  logic [PW-1:0] core, cross_a, cross_b, corner, bin_p;
  logic [PW-1:0] tens, units;
  logic [PW+6:0] scaled;

  assign a_top = op_a[DW-1];
  assign b_top = op_b[DW-1];
  assign a_low = op_a[LW-1:0];
  assign b_low = op_b[LW-1:0];

  always_comb begin
    core = '0;
    for (int i = 0; i < LW; i++)
      if (b_low[i]) core = core + (PW'(a_low) << i);
  end

  assign cross_a = a_top ? (PW'(b_low) << LW) : '0;
  assign cross_b = b_top ? (PW'(a_low) << LW) : '0;
  assign corner  = (a_top && b_top) ? (PW'(1) << (2 * LW)) : '0;
  assign bin_p   = core + cross_a + cross_b + corner;

  assign bad_digit = !hex_sel && (op_a > DW'(9) || op_b > DW'(9));

  assign scaled = (PW+7)'(bin_p) * (PW+7)'(103);
  assign tens   = PW'(scaled >> 10);
  assign units  = bin_p - PW'(tens * PW'(10));

  always_comb begin
    if (hex_sel)        prod = bin_p;
    else if (bad_digit) prod = '0;
    else                prod = {tens[DW-1:0], units[DW-1:0]};
  end
endmodule

module digit_mul_chk #(
  parameter int DW = 4
) (
  input logic [DW-1:0]   op_a,
  input logic [DW-1:0]   op_b,
  input logic            hex_sel,
  input logic [2*DW-1:0] prod,
  input logic            bad_digit
);
  always_comb begin
    if (hex_sel) begin
      assert_hex_exact_R1: assert (int'(prod) == int'(op_a) * int'(op_b));
      assert_hex_no_flag_R2: assert (!bad_digit);
    end else if (op_a <= DW'(9) && op_b <= DW'(9)) begin
      assert_dec_value_R3: assert (int'(prod[7:4]) * 10 + int'(prod[3:0]) == int'(op_a) * int'(op_b));
      assert_dec_digits_R4: assert (prod[7:4] <= 4'd9 && prod[3:0] <= 4'd9);
      assert_dec_flag_low_R5: assert (!bad_digit);
    end else begin
      assert_bad_zero_R5: assert (bad_digit && prod == '0);
    end
  end
endmodule

bind digit_mul digit_mul_chk #(.DW(DW)) u_chk (
  .op_a(op_a), .op_b(op_b), .hex_sel(hex_sel), .prod(prod), .bad_digit(bad_digit)
);

// File: tb/digit_mul_tb.sv
module digit_mul_tb;
  logic       clk = 1'b0;
  logic [3:0] op_a, op_b;
  logic       hex_sel;
  logic [7:0] prod;
  logic       bad_digit;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  digit_mul u_dut (.op_a(op_a), .op_b(op_b), .hex_sel(hex_sel), .prod(prod), .bad_digit(bad_digit));

  function automatic logic [7:0] exp_prod(input int a, input int b, input bit hx);
    int p = a * b;
    if (hx) return 8'(p);
    if (a > 9 || b > 9) return 8'h00;
    return {4'(p / 10), 4'(p % 10)};
  endfunction

  function automatic bit exp_bad(input int a, input int b, input bit hx);
    return !hx && (a > 9 || b > 9);
  endfunction

  task automatic apply(input int a, input int b, input bit hx, input string req);
    logic [7:0] ep;
    logic eb;
    @(negedge clk);
    op_a = 4'(a); op_b = 4'(b); hex_sel = hx;
    #2;
    ep = exp_prod(a, b, hx);
    eb = exp_bad(a, b, hx);
    n_chk++;
    if (prod !== ep || bad_digit !== eb) begin
      n_bad++;
      $display("FAIL %s a=%0d b=%0d hex=%0d: prod=%h bad=%b expected prod=%h bad=%b",
               req, a, b, hx, prod, bad_digit, ep, eb);
    end
  endtask

  initial begin
    op_a = 0; op_b = 0; hex_sel = 0;
    apply(0, 0, 0, "R7 idle");
    apply(8, 8, 0, "R6"); apply(8, 9, 0, "R6");
    apply(9, 8, 0, "R6"); apply(9, 9, 0, "R6");
    apply(0, 9, 0, "R7"); apply(15, 0, 1, "R7"); apply(15, 15, 1, "R1");
    apply(10, 3, 0, "R5"); apply(3, 12, 0, "R5"); apply(9, 9, 1, "R1");
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        apply(a, b, 0, (a > 9 || b > 9) ? "R5" : "R3/R4");
        apply(a, b, 1, "R1/R2");
      end
    void'($urandom(32'd7719));
    for (int k = 0; k < 300; k++)
      apply(int'($urandom % 16), int'($urandom % 16), bit'($urandom % 2), "R8 random");
    apply(9, 9, 0, "R8 revisit");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule